// File: doc/BRIEF.md
# Preloaded Loop Instruction Buffer

This block sits between a processor's fetch stage and its level-one instruction memory. It holds a small, tagless array of instruction words and a handful of loop descriptors. Software fills both through a load port while the block is stopped. Once the run enable is raised, that content is frozen. Each descriptor names the first and last fetch address of one loop and the buffer slot where that loop's first word was placed.

On every fetch the controller decides, in the same cycle, whether the word comes from the buffer or from L1. A loop is entered in one of two ways, chosen at elaboration. In entry-on-start mode, any fetch of a descriptor's first address enters the loop, so even the first iteration is served locally. In entry-on-branch mode, the fetch must follow a fetch that reported a taken short backward branch, so the first iteration always comes from L1. After entry, any fetch inside the loop's address range is served from the buffer, including jumps inside the loop body. The first fetch outside the range goes to L1, and the descriptors are checked again for that address.

The buffer slot is the fetch address minus the loop's first address plus the descriptor's base slot. A hit raises the source select and suppresses the L1 read.

Top module: `preload_loop_cache`

## Requirements
- R1: While `run_en` is low, `ld_buf_we` writes `ld_buf_data` into slot `ld_buf_idx`, and `ld_reg_we` writes the valid bit, first address, last address and base slot of descriptor `ld_reg_sel`. Later hits return the written words.
- R2: While `run_en` is high, both load strobes are ignored. Buffer words and descriptors keep their earlier values.
- R3: A fetch that misses sets `l1_rd` = 1, `l1_addr` = `fetch_addr` and `src_lc` = 0 in the same cycle. With `fetch_vld` low, both `l1_rd` and `src_lc` are 0.
- R4: In entry-on-start mode, a fetch whose address equals the first address of a valid descriptor hits in that cycle. `lc_data` = buffer[(fetch_addr − first + base) mod DEPTH].
- R5: In entry-on-branch mode, a first-address match hits only when the previous accepted fetch had `fetch_sbb` = 1. Otherwise the fetch goes to L1.
- R6: After a hit, every later fetch whose address lies in the active loop's inclusive [first, last] range hits. This holds in any order, so jumps inside the loop keep buffer fetching going.
- R7: A fetch outside the active range misses the active loop. In the same cycle the descriptors are checked again, so it can enter another loop under the rules of R4/R5.
- R8: A descriptor whose valid bit is 0 never produces a hit.
- R9: When several valid descriptors share a first address, the one with the lowest index is used.
- R10: While `run_en` is low, `src_lc` stays 0 and the active loop and branch flag are cleared. After re-enable, an address inside a loop body misses until the loop is entered again.
- R11: After reset, every descriptor is invalid, so no fetch hits until descriptors are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Program running; blocks loading and enables hits |
| ld_buf_we | input | 1 | Buffer word write strobe |
| ld_buf_idx | input | IDX_W | Buffer slot to write |
| ld_buf_data | input | DATA_W | Buffer word |
| ld_reg_we | input | 1 | Descriptor write strobe |
| ld_reg_sel | input | SEL_W | Descriptor index |
| ld_reg_valid | input | 1 | Descriptor valid bit |
| ld_reg_first | input | ADDR_W | Loop first fetch address |
| ld_reg_last | input | ADDR_W | Loop last fetch address (inclusive) |
| ld_reg_base | input | IDX_W | Buffer slot of the loop's first word |
| fetch_vld | input | 1 | Fetch request this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_sbb | input | 1 | Fetched instruction is a taken short backward branch |
| l1_rd | output | 1 | Read L1 at `l1_addr` |
| l1_addr | output | ADDR_W | L1 read address |
| src_lc | output | 1 | 1 = take `lc_data`, 0 = take L1 |
| lc_data | output | DATA_W | Buffer word for the current fetch |

## Verification
The hardest case to reach is the boundary between two loops: a fetch leaves one loop's range and, in the same cycle, lands on the first address of another descriptor, or on a first address shared by a valid and an invalid descriptor. The stimulus uses overlapping descriptors that share a first address. It drives direct jumps out of one loop body to another loop's first address, with and without a preceding backward-branch flag. Two instances, one per entry mode, see identical traffic. A full 256-address sweep with a periodic branch flag ends the run.

// File: rtl/plc_pkg.sv
package plc_pkg;
   typedef enum logic {
      MODE_START_ADDR  = 1'b0,
      MODE_BACK_BRANCH = 1'b1
   } plc_mode_e;
endpackage

// File: rtl/plc_store.sv
module plc_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_idx] <= wr_data;
   end

   assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/plc_loop_table.sv
module plc_loop_table #(
   parameter int ADDR_W    = 16,
   parameter int IDX_W     = 6,
   parameter int NUM_LOOPS = 4,
   parameter int SEL_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic                 wr_valid,
   input  logic [ADDR_W-1:0]    wr_first,
   input  logic [ADDR_W-1:0]    wr_last,
   input  logic [IDX_W-1:0]     wr_base,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_LOOPS-1:0] start_hit,
   output logic [NUM_LOOPS-1:0] in_range,
   input  logic [SEL_W-1:0]     rd_sel,
   output logic [ADDR_W-1:0]    rd_first,
   output logic [IDX_W-1:0]     rd_base
);
   logic [ADDR_W-1:0] first_w [NUM_LOOPS];
   logic [IDX_W-1:0]  base_w  [NUM_LOOPS];

   for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_entry
      logic              vld_q;
      logic [ADDR_W-1:0] first_q, last_q;
      logic [IDX_W-1:0]  base_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q   <= 1'b0;
            first_q <= '0;
            last_q  <= '0;
            base_q  <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(g))) begin
            vld_q   <= wr_valid;
            first_q <= wr_first;
            last_q  <= wr_last;
            base_q  <= wr_base;
         end
      end

      assign start_hit[g] = vld_q && (addr == first_q);
      assign in_range[g]  = vld_q && (addr >= first_q) && (addr <= last_q);
      assign first_w[g]   = first_q;
      assign base_w[g]    = base_q;
   end

   assign rd_first = first_w[rd_sel];
   assign rd_base  = base_w[rd_sel];
endmodule

// File: rtl/plc_ctrl.sv
module plc_ctrl
   import plc_pkg::*;
#(
   parameter int        NUM_LOOPS = 4,
   parameter int        SEL_W     = 2,
   parameter plc_mode_e MODE      = MODE_BACK_BRANCH
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_en,
   input  logic                 fetch_vld,
   input  logic                 fetch_sbb,
   input  logic [NUM_LOOPS-1:0] start_hit,
   input  logic [NUM_LOOPS-1:0] in_range,
   output logic                 hit,
   output logic [SEL_W-1:0]     hit_sel
);
   logic             active_q, armed_q;
   logic [SEL_W-1:0] act_sel_q;
   logic [SEL_W-1:0] first_sel;
   logic             entry_ok, stay;

   if (MODE == MODE_START_ADDR) begin : g_entry_start
      assign entry_ok = 1'b1;
   end else begin : g_entry_branch
      assign entry_ok = armed_q;
   end

   always_comb begin
      first_sel = '0;
      for (int k = NUM_LOOPS - 1; k >= 0; k--) begin
         if (start_hit[k]) first_sel = SEL_W'(k);
      end
   end

   assign stay    = active_q && in_range[act_sel_q];
   assign hit     = fetch_vld && run_en && (stay || ((|start_hit) && entry_ok));
   assign hit_sel = stay ? act_sel_q : first_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         armed_q   <= 1'b0;
         act_sel_q <= '0;
      end else if (!run_en) begin
         active_q  <= 1'b0;
         armed_q   <= 1'b0;
      end else if (fetch_vld) begin
         active_q  <= hit;
         act_sel_q <= hit_sel;
         armed_q   <= fetch_sbb;
      end
   end
endmodule

// File: rtl/preload_loop_cache.sv
module preload_loop_cache
   import plc_pkg::*;
#(
   parameter int        ADDR_W    = 16,
   parameter int        DATA_W    = 32,
   parameter int        DEPTH     = 64,
   parameter int        NUM_LOOPS = 4,
   parameter plc_mode_e MODE      = MODE_BACK_BRANCH,
   localparam int       IDX_W     = $clog2(DEPTH),
   localparam int       SEL_W     = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              ld_buf_we,
   input  logic [IDX_W-1:0]  ld_buf_idx,
   input  logic [DATA_W-1:0] ld_buf_data,
   input  logic              ld_reg_we,
   input  logic [SEL_W-1:0]  ld_reg_sel,
   input  logic              ld_reg_valid,
   input  logic [ADDR_W-1:0] ld_reg_first,
   input  logic [ADDR_W-1:0] ld_reg_last,
   input  logic [IDX_W-1:0]  ld_reg_base,
   input  logic              fetch_vld,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_sbb,
   output logic              l1_rd,
   output logic [ADDR_W-1:0] l1_addr,
   output logic              src_lc,
   output logic [DATA_W-1:0] lc_data
);
   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W must cover the buffer index");
   end
   if (MODE == MODE_START_ADDR && (NUM_LOOPS < 2 || NUM_LOOPS > 3)) begin : g_bad_start
      $error("entry-on-start mode takes 2 to 3 descriptors");
   end
   if (MODE == MODE_BACK_BRANCH && (NUM_LOOPS < 2 || NUM_LOOPS > 6)) begin : g_bad_branch
      $error("entry-on-branch mode takes 2 to 6 descriptors");
   end

   logic                 load_ok;
   logic [NUM_LOOPS-1:0] start_hit, in_range;
   logic                 hit;
   logic [SEL_W-1:0]     hit_sel;
   logic [ADDR_W-1:0]    rd_first, rel_addr;
   logic [IDX_W-1:0]     rd_base, rd_idx;

   assign load_ok = !run_en;

   plc_loop_table #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_LOOPS(NUM_LOOPS), .SEL_W(SEL_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ld_reg_we && load_ok), .wr_sel(ld_reg_sel), .wr_valid(ld_reg_valid),
      .wr_first(ld_reg_first), .wr_last(ld_reg_last), .wr_base(ld_reg_base),
      .addr(fetch_addr), .start_hit(start_hit), .in_range(in_range),
      .rd_sel(hit_sel), .rd_first(rd_first), .rd_base(rd_base)
   );

   plc_ctrl #(
      .NUM_LOOPS(NUM_LOOPS), .SEL_W(SEL_W), .MODE(MODE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .fetch_vld(fetch_vld), .fetch_sbb(fetch_sbb),
      .start_hit(start_hit), .in_range(in_range),
      .hit(hit), .hit_sel(hit_sel)
   );

   assign rel_addr = fetch_addr - rd_first;
   assign rd_idx   = rel_addr[IDX_W-1:0] + rd_base;

   plc_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .wr_en(ld_buf_we && load_ok), .wr_idx(ld_buf_idx),
      .wr_data(ld_buf_data), .rd_idx(rd_idx), .rd_data(lc_data)
   );

   assign src_lc  = hit;
   assign l1_rd   = fetch_vld && !hit;
   assign l1_addr = fetch_addr;
endmodule

// File: rtl/preload_loop_cache_chk.sv
module preload_loop_cache_chk
   import plc_pkg::*;
#(
   parameter int        ADDR_W = 16,
   parameter plc_mode_e MODE   = MODE_BACK_BRANCH
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              fetch_vld,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              fetch_sbb,
   input logic              l1_rd,
   input logic [ADDR_W-1:0] l1_addr,
   input logic              src_lc
);
   logic prev_hit, prev_sbb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_hit <= 1'b0;
         prev_sbb <= 1'b0;
      end else if (!run_en) begin
         prev_hit <= 1'b0;
         prev_sbb <= 1'b0;
      end else if (fetch_vld) begin
         prev_hit <= src_lc;
         prev_sbb <= fetch_sbb;
      end
   end

   a_r3_miss_goes_to_l1: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld && !src_lc) |-> (l1_rd && (l1_addr == fetch_addr)));

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_vld |-> (!l1_rd && !src_lc));

   a_r6_single_source: assert property (@(posedge clk) disable iff (!rst_n)
      src_lc |-> !l1_rd);

   a_r10_stopped_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !src_lc);

   if (MODE == MODE_BACK_BRANCH) begin : g_branch_chk
      a_r5_entry_after_branch: assert property (@(posedge clk) disable iff (!rst_n)
         (fetch_vld && src_lc && !prev_hit) |-> prev_sbb);
   end
endmodule

bind preload_loop_cache preload_loop_cache_chk #(.ADDR_W(ADDR_W), .MODE(MODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .fetch_vld(fetch_vld),
   .fetch_addr(fetch_addr), .fetch_sbb(fetch_sbb), .l1_rd(l1_rd),
   .l1_addr(l1_addr), .src_lc(src_lc)
);

// File: tb/test_preload_loop_cache.sv
`timescale 1ns/1ps
module test_preload_loop_cache;
   import plc_pkg::*;

   localparam int AW = 8, DW = 16, DP = 16, NL = 3, IW = 4, SW = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0, run_en = 1'b0;
   logic          ld_buf_we = 1'b0, ld_reg_we = 1'b0, ld_reg_valid = 1'b0;
   logic [IW-1:0] ld_buf_idx = '0, ld_reg_base = '0;
   logic [DW-1:0] ld_buf_data = '0;
   logic [SW-1:0] ld_reg_sel = '0;
   logic [AW-1:0] ld_reg_first = '0, ld_reg_last = '0, fetch_addr = '0;
   logic          fetch_vld = 1'b0, fetch_sbb = 1'b0;

   logic          l1_rd [2], src_lc [2];
   logic [AW-1:0] l1_addr [2];
   logic [DW-1:0] lc_data [2];

   preload_loop_cache #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .NUM_LOOPS(NL),
      .MODE(MODE_START_ADDR)) i_preload_loop_cache (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .ld_buf_we(ld_buf_we), .ld_buf_idx(ld_buf_idx), .ld_buf_data(ld_buf_data),
      .ld_reg_we(ld_reg_we), .ld_reg_sel(ld_reg_sel), .ld_reg_valid(ld_reg_valid),
      .ld_reg_first(ld_reg_first), .ld_reg_last(ld_reg_last), .ld_reg_base(ld_reg_base),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .fetch_sbb(fetch_sbb),
      .l1_rd(l1_rd[0]), .l1_addr(l1_addr[0]), .src_lc(src_lc[0]), .lc_data(lc_data[0]));

   preload_loop_cache #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .NUM_LOOPS(NL),
      .MODE(MODE_BACK_BRANCH)) i_preload_loop_cache_sbb (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .ld_buf_we(ld_buf_we), .ld_buf_idx(ld_buf_idx), .ld_buf_data(ld_buf_data),
      .ld_reg_we(ld_reg_we), .ld_reg_sel(ld_reg_sel), .ld_reg_valid(ld_reg_valid),
      .ld_reg_first(ld_reg_first), .ld_reg_last(ld_reg_last), .ld_reg_base(ld_reg_base),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .fetch_sbb(fetch_sbb),
      .l1_rd(l1_rd[1]), .l1_addr(l1_addr[1]), .src_lc(src_lc[1]), .lc_data(lc_data[1]));

   // reference state, built from the requirements
   logic [DW-1:0] m_buf [DP];
   logic          m_vld [NL];
   logic [AW-1:0] m_first [NL], m_last [NL];
   logic [IW-1:0] m_base [NL];
   logic          m_act [2], m_armed [2];
   int            m_sel [2];
   int            n_vec = 0, n_bad = 0;

   function automatic logic [DW-1:0] word_of(int i);
      return DW'(i * 16'h1357 + 16'h00A5);
   endfunction

   task automatic report_bad(string req, string what, int m, longint act, longint exp);
      n_bad++;
      $display("FAIL %s inst%0d %s: actual=%0h expected=%0h", req, m, what, act, exp);
   endtask

   task automatic idle(string req);
      @(negedge clk);
      fetch_vld = 1'b0; fetch_sbb = 1'b0;
      #2;
      for (int m = 0; m < 2; m++) begin
         n_vec++;
         if (l1_rd[m] !== 1'b0 || src_lc[m] !== 1'b0)
            report_bad(req, "idle l1_rd/src_lc", m, {l1_rd[m], src_lc[m]}, 0);
      end
   endtask

   task automatic fetch(logic [AW-1:0] a, logic sbb, string req);
      logic hit [2];
      int   sel [2];
      @(negedge clk);
      fetch_vld = 1'b1; fetch_addr = a; fetch_sbb = sbb;
      #2;
      for (int m = 0; m < 2; m++) begin
         hit[m] = 1'b0; sel[m] = 0;
         if (run_en) begin
            if (m_act[m] && m_vld[m_sel[m]] && a >= m_first[m_sel[m]] && a <= m_last[m_sel[m]]) begin
               hit[m] = 1'b1; sel[m] = m_sel[m];
            end else begin
               for (int k = 0; k < NL; k++)
                  if (!hit[m] && m_vld[k] && a == m_first[k] && (m == 0 || m_armed[m])) begin
                     hit[m] = 1'b1; sel[m] = k;
                  end
            end
         end
         n_vec++;
         if (src_lc[m] !== hit[m] || l1_rd[m] !== !hit[m] || l1_addr[m] !== a)
            report_bad(req, "src_lc/l1_rd/l1_addr", m, {src_lc[m], l1_rd[m], l1_addr[m]},
                       {hit[m], !hit[m], a});
         else if (hit[m]) begin
            logic [DW-1:0] w;
            w = m_buf[IW'(a - m_first[sel[m]]) + m_base[sel[m]]];
            if (lc_data[m] !== w) report_bad(req, "lc_data", m, lc_data[m], w);
         end
      end
      if (run_en)
         for (int m = 0; m < 2; m++) begin
            m_act[m] = hit[m]; m_sel[m] = sel[m]; m_armed[m] = sbb;
         end
   endtask

   task automatic set_run(logic v);
      @(negedge clk);
      fetch_vld = 1'b0; run_en = v;
      if (!v)
         for (int m = 0; m < 2; m++) begin m_act[m] = 1'b0; m_armed[m] = 1'b0; end
   endtask

   task automatic load_word(int i, logic [DW-1:0] d);
      @(negedge clk);
      fetch_vld = 1'b0; ld_buf_we = 1'b1; ld_buf_idx = IW'(i); ld_buf_data = d;
      if (!run_en) m_buf[i] = d;
      @(negedge clk);
      ld_buf_we = 1'b0;
   endtask

   task automatic load_desc(int s, logic v, logic [AW-1:0] f, logic [AW-1:0] l, logic [IW-1:0] b);
      @(negedge clk);
      fetch_vld = 1'b0; ld_reg_we = 1'b1; ld_reg_sel = SW'(s);
      ld_reg_valid = v; ld_reg_first = f; ld_reg_last = l; ld_reg_base = b;
      if (!run_en) begin m_vld[s] = v; m_first[s] = f; m_last[s] = l; m_base[s] = b; end
      @(negedge clk);
      ld_reg_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < NL; k++) begin
         m_vld[k] = 1'b0; m_first[k] = '0; m_last[k] = '0; m_base[k] = '0;
      end
      for (int i = 0; i < DP; i++) m_buf[i] = '0;
      for (int m = 0; m < 2; m++) begin m_act[m] = 1'b0; m_armed[m] = 1'b0; m_sel[m] = 0; end

      // R11: reset leaves every descriptor invalid
      repeat (3) @(negedge clk);
      idle("R11");
      rst_n = 1'b1;
      set_run(1'b1);
      fetch(8'h20, 1'b1, "R11");
      fetch(8'h20, 1'b0, "R11");

      // R1: preload while stopped
      set_run(1'b0);
      for (int i = 0; i < DP; i++) load_word(i, word_of(i));
      load_desc(0, 1'b1, 8'h20, 8'h25, 4'd0);
      load_desc(1, 1'b1, 8'h40, 8'h43, 4'd6);
      load_desc(2, 1'b1, 8'h20, 8'h22, 4'd10);
      set_run(1'b1);
      idle("R3");
      fetch(8'h20, 1'b0, "R1");

      // R4: straight-line sweep; start mode hits on first pass, branch mode misses
      for (int a = 8'h1C; a <= 8'h48; a++) fetch(AW'(a), 1'b0, "R4");

      // R5: three iterations closing with a backward branch
      for (int it = 0; it < 3; it++)
         for (int a = 8'h20; a <= 8'h25; a++) fetch(AW'(a), a == 8'h25, "R5");

      // R6: jumps inside the loop body keep buffer fetching
      for (int it = 0; it < 2; it++) begin
         fetch(8'h20, 1'b0, "R6"); fetch(8'h21, 1'b0, "R6"); fetch(8'h24, 1'b0, "R6");
         fetch(8'h22, 1'b0, "R6"); fetch(8'h25, 1'b1, "R6");
      end
      idle("R3");
      fetch(8'h23, 1'b0, "R6");

      // R7: leave the range, re-check in the same cycle
      fetch(8'h26, 1'b0, "R7");
      fetch(8'h40, 1'b0, "R7");
      fetch(8'h25, 1'b1, "R7");
      fetch(8'h20, 1'b0, "R7");
      fetch(8'h21, 1'b1, "R7");
      fetch(8'h40, 1'b0, "R7");
      fetch(8'h43, 1'b0, "R7");

      // R9: shared first address resolves to the lowest index
      fetch(8'h25, 1'b1, "R9");
      fetch(8'h20, 1'b0, "R9");
      fetch(8'h24, 1'b0, "R9");

      // R10: stopping clears the active loop
      fetch(8'h22, 1'b0, "R10");
      set_run(1'b0);
      fetch(8'h23, 1'b0, "R10");
      set_run(1'b1);
      fetch(8'h23, 1'b0, "R10");

      // R2: load strobes ignored while running
      load_word(0, 16'hDEAD);
      load_desc(0, 1'b0, 8'h80, 8'h81, 4'd3);
      fetch(8'h25, 1'b1, "R2");
      fetch(8'h20, 1'b0, "R2");
      fetch(8'h21, 1'b0, "R2");

      // R8: invalidate descriptor 0; shared start now selects descriptor 2
      set_run(1'b0);
      load_desc(0, 1'b0, 8'h20, 8'h25, 4'd0);
      set_run(1'b1);
      fetch(8'h1F, 1'b0, "R8");
      fetch(8'h20, 1'b0, "R8");
      fetch(8'h22, 1'b1, "R8");
      fetch(8'h20, 1'b0, "R8");
      fetch(8'h21, 1'b0, "R8");
      fetch(8'h23, 1'b0, "R8");
      fetch(8'h25, 1'b0, "R8");

      // full address sweep with a periodic branch flag
      for (int a = 0; a < 256; a++) fetch(AW'(a), (a % 7) == 0, "R7");
      idle("R3");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule